// File: doc/BRIEF.md
# Watchdog Timer with Protected Reconfiguration

This block supervises software. While enabled, it counts pulses from a slow, free-running timebase. If software does not send a restart strobe before the count reaches the selected period, the block raises a one-cycle system-reset request. The period comes from a 4-bit code. Code 0 is a base period of `BASE_TICKS` timebase ticks, and each higher code doubles it, up to code 9. Codes 10 to 15 behave as code 9.

Software sees the block through one 8-bit control register, with a write strobe, write data and a combinational read-back. A runaway program must not be able to weaken the watchdog with a single store. So the enable bit and the period code change only through a two-write sequence:

- An unlock write opens a short window of `WIN_CYCLES` clock cycles.
- A configuration write must land inside that window.

The block keeps a flag that records a watchdog-caused reset. While that flag is set, the watchdog cannot be disabled. A force-on input has the same effect. After any reset other than power-on, the watchdog comes back armed at the shortest period.

Register layout:

| Bit | Field |
|-----|-------|
| 2:0 | Period code bits 2:0 |
| 3 | Enable |
| 4 | Unlock / window open |
| 5 | Period code bit 3 |
| 6 | Watchdog-reset flag |
| 7 | Reads 0 |

Top module: `wdog_guard`

## Requirements
- R1: When `por` is high at a clock edge, the block clears the flag, the period code, the window and the count, and drops `wdt_reset`. The enable bit takes the value of `force_on`, so read-back is 0x00 with `force_on` low and 0x08 with it high.
- R2: Read-back places the period code's bits 2:0 at bits 2:0, enable at bit 3, window-open at bit 4, code bit 3 at bit 5 and the flag at bit 6, and bit 7 reads 0. A configuration write takes the code from bits 5 and 2:0 and the enable from bit 3.
- R3: A write with bits 4 and 3 both set, made while the window is closed, opens the window (read-back bit 4 becomes 1). It changes neither the enable bit nor the period code.
- R4: A write that arrives at any of the `WIN_CYCLES` clock edges after the unlock edge is accepted as the configuration write, and it closes the window. If no write comes, bit 4 reads 0 after `WIN_CYCLES` edges, and later writes leave the enable bit and the period code unchanged.
- R5: Unlocking and then writing 0x00 inside the window clears the enable bit, provided the flag is clear and `force_on` is low.
- R6: With the watchdog enabled, the clock edge that carries the Nth `tick` since the count was cleared starts a one-cycle `wdt_reset` pulse, where N = `BASE_TICKS` << min(code, 9). The same edge returns the count to zero.
- R7: A `kick` clears the count, and it takes priority over a `tick` in the same cycle. While the watchdog is disabled, the count stays at zero and `wdt_reset` stays low.
- R8: A `sys_rst` edge (without `por`) sets the enable bit to 1, sets the period code to 0, closes the window and clears the count. The flag is kept.
- R9: The edge that starts `wdt_reset` sets the flag. Any write with bit 6 at 0 clears the flag, unless a reset fires at the same edge. If the flag was set before an accepted configuration write, that write leaves the enable bit at 1.
- R10: While `force_on` is high, an accepted configuration write leaves the enable bit at 1.
- R11: An accepted configuration write clears the count.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| por | input | 1 | Power-on reset, synchronous, active high |
| sys_rst | input | 1 | Any other system reset, synchronous, active high |
| tick | input | 1 | One-cycle pulse from the slow timebase |
| kick | input | 1 | One-cycle restart strobe from software |
| force_on | input | 1 | Configuration input that keeps the watchdog enabled |
| wr_en | input | 1 | Control register write strobe |
| wr_data | input | 8 | Control register write data |
| rd_data | output | 8 | Control register read-back |
| wdt_reset | output | 1 | One-cycle system reset request |

## Verification
A wrong enable bit, period code or window state shows up on `rd_data` in the cycle right after the faulty edge. The bench compares the whole read-back every cycle, so such faults are seen at once. A wrong count or period decode is only visible through `wdt_reset`, and only when the expiry edge comes early or late. For that reason, the directed cases measure the exact edge count to expiry for codes 1, 3 and 12, and a cycle-accurate reference tracks expiry across thousands of random cycles. A wrong flag appears at bit 6 on the edge after expiry, and again later as a disable that should have been refused.

// File: rtl/wdog_guard.sv
`timescale 1ns/1ps
module wdog_guard #(
  parameter int BASE_TICKS = 2,
  parameter int WIN_CYCLES = 4
) (
  input  logic       clk,
  input  logic       por,
  input  logic       sys_rst,
  input  logic       tick,
  input  logic       kick,
  input  logic       force_on,
  input  logic       wr_en,
  input  logic [7:0] wr_data,
  output logic [7:0] rd_data,
  output logic       wdt_reset
);
  localparam int MAX_CODE   = 9;
  localparam int PERIOD_MAX = BASE_TICKS << MAX_CODE;
  localparam int CW         = $clog2(PERIOD_MAX + 1);
  localparam int WW         = $clog2(WIN_CYCLES + 1);
  localparam int B_EN       = 3;
  localparam int B_CE       = 4;
  localparam int B_SELHI    = 5;
  localparam int B_FLAG     = 6;

  logic          en, flag, rst_q;
  logic [3:0]    sel;
  logic [WW-1:0] win;
  logic [CW-1:0] cnt;

  wire           win_open = (win != '0);
  wire           accept   = wr_en && win_open;
  wire           unlock   = wr_en && !win_open && wr_data[B_CE] && wr_data[B_EN];
  wire [3:0]     wr_sel   = {wr_data[B_SELHI], wr_data[2:0]};
  wire [3:0]     eff_sel  = (sel > 4'(MAX_CODE)) ? 4'(MAX_CODE) : sel;
  wire [CW-1:0]  period   = CW'(BASE_TICKS) << eff_sel;
  wire           expire   = en && tick && !kick && !accept && (cnt == period - 1'b1);

  always_ff @(posedge clk) begin
    if (por) begin
      en    <= force_on;
      sel   <= '0;
      win   <= '0;
      flag  <= 1'b0;
      cnt   <= '0;
      rst_q <= 1'b0;
    end else if (sys_rst) begin
      en    <= 1'b1;
      sel   <= '0;
      win   <= '0;
      cnt   <= '0;
      rst_q <= 1'b0;
    end else begin
      rst_q <= expire;
      if (expire)                      flag <= 1'b1;
      else if (wr_en && !wr_data[B_FLAG]) flag <= 1'b0;
      if (accept) begin
        en  <= wr_data[B_EN] | flag | force_on;
        sel <= wr_sel;
        win <= '0;
      end else if (unlock) begin
        win <= WW'(WIN_CYCLES);
      end else if (win_open) begin
        win <= win - 1'b1;
      end
      if (!en || kick || accept || expire) cnt <= '0;
      else if (tick)                       cnt <= cnt + 1'b1;
    end
  end

  assign rd_data   = {1'b0, flag, sel[3], win_open, en, sel[2:0]};
  assign wdt_reset = rst_q;

  assert_pulse_one_R6: assert property (@(posedge clk) disable iff (por)
    wdt_reset |=> !wdt_reset);
  assert_cnt_bound_R6: assert property (@(posedge clk) disable iff (por)
    en |-> (cnt < period));
  assert_fire_flag_R9: assert property (@(posedge clk) disable iff (por)
    wdt_reset |-> flag);
  assert_flag_holds_en_R9: assert property (@(posedge clk) disable iff (por)
    (flag && !por) |=> en);
  assert_force_holds_en_R10: assert property (@(posedge clk) disable iff (por)
    (force_on && en && !por) |=> en);
  assert_locked_cfg_R4: assert property (@(posedge clk) disable iff (por)
    (!win_open && !sys_rst && !por) |=> ($stable(en) && $stable(sel)));
  assert_disabled_idle_R7: assert property (@(posedge clk) disable iff (por)
    (!en && !por && !sys_rst) |=> !wdt_reset);
endmodule

// File: tb/wdog_guard_bench.sv
`timescale 1ns/1ps
module wdog_guard_bench;
  localparam int BASE = 2;
  localparam int WIN  = 4;

  logic       clk = 1'b0;
  logic       por = 1'b1, sys_rst = 1'b0, tick = 1'b0, kick = 1'b0, force_on = 1'b0, wr_en = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic [7:0] rd_data;
  logic       wdt_reset;

  int checks = 0;
  int failures = 0;

  logic     m_en = 1'b0, m_flag = 1'b0, m_rst = 1'b0;
  logic [3:0] m_sel = 4'd0;
  int       m_win = 0, m_cnt = 0;

  always #5 clk = ~clk;

  wdog_guard #(.BASE_TICKS(BASE), .WIN_CYCLES(WIN)) u_wdog_guard (
    .clk(clk), .por(por), .sys_rst(sys_rst), .tick(tick), .kick(kick),
    .force_on(force_on), .wr_en(wr_en), .wr_data(wr_data),
    .rd_data(rd_data), .wdt_reset(wdt_reset));

  function automatic int exp_period(input logic [3:0] code);
    return BASE << ((code > 4'd9) ? 9 : int'(code));
  endfunction

  function automatic logic [7:0] exp_rd();
    return {1'b0, m_flag, m_sel[3], (m_win > 0), m_en, m_sel[2:0]};
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic model_step(input logic p, s, t, k, f, w, input logic [7:0] d);
    logic open, acc, unl, ex;
    if (p) begin
      m_en = f; m_sel = 0; m_win = 0; m_flag = 0; m_cnt = 0; m_rst = 0;
    end else if (s) begin
      m_en = 1; m_sel = 0; m_win = 0; m_cnt = 0; m_rst = 0;
    end else begin
      open = (m_win > 0);
      acc  = w && open;
      unl  = w && !open && d[4] && d[3];
      ex   = m_en && t && !k && !acc && (m_cnt == exp_period(m_sel) - 1);
      if (!m_en || k || acc || ex) m_cnt = 0;
      else if (t) m_cnt = m_cnt + 1;
      if (acc) begin
        m_en  = d[3] | m_flag | f;
        m_sel = {d[5], d[2:0]};
        m_win = 0;
      end else if (unl) m_win = WIN;
      else if (open) m_win = m_win - 1;
      if (ex) m_flag = 1;
      else if (w && !d[6]) m_flag = 0;
      m_rst = ex;
    end
  endtask

  task automatic step(input logic p, s, t, k, f, w, input logic [7:0] d);
    por = p; sys_rst = s; tick = t; kick = k; force_on = f; wr_en = w; wr_data = d;
    model_step(p, s, t, k, f, w, d);
    @(posedge clk);
    @(negedge clk);
    chk("R2 rd_data vs model", {24'd0, rd_data}, {24'd0, exp_rd()});
    chk("R6 wdt_reset vs model", {31'd0, wdt_reset}, {31'd0, m_rst});
  endtask

  task automatic idle(input logic t);
    step(0, 0, t, 0, force_on, 0, 8'h00);
  endtask

  task automatic wr(input logic [7:0] d);
    step(0, 0, 0, 0, force_on, 1, d);
  endtask

  initial begin
    #(200000 * 10);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    int n;
    logic any;
    logic [31:0] seed;
    seed = $urandom(32'h5eed);
    @(negedge clk);
    step(1, 0, 0, 0, 0, 0, 8'h00);
    step(1, 0, 0, 0, 0, 0, 8'h00);
    chk("R1 rd after por", {24'd0, rd_data}, 32'h00);
    chk("R1 wdt_reset after por", {31'd0, wdt_reset}, 0);

    wr(8'h18);
    chk("R3 window opens, cfg unchanged", {24'd0, rd_data}, 32'h10);
    wr(8'h0B);
    chk("R4 accepted code 3 enabled", {24'd0, rd_data}, 32'h0B);
    any = 0;
    for (int i = 0; i < 15; i++) begin idle(1); any |= wdt_reset; end
    chk("R6 no early reset code 3", {31'd0, any}, 0);
    idle(1);
    chk("R6 reset at tick 16", {31'd0, wdt_reset}, 1);
    chk("R9 flag set after fire", {24'd0, rd_data}, 32'h4B);

    step(0, 1, 0, 0, 0, 0, 8'h00);
    chk("R8 non-por reset armed code 0 flag kept", {24'd0, rd_data}, 32'h48);
    wr(8'h58);
    wr(8'h40);
    chk("R9 flag blocks disable", {24'd0, rd_data}, 32'h48);
    wr(8'h00);
    chk("R9 write clears flag", {24'd0, rd_data}, 32'h08);
    wr(8'h18);
    wr(8'h00);
    chk("R5 disable sequence", {24'd0, rd_data}, 32'h00);

    wr(8'h18);
    for (int i = 0; i < 3; i++) idle(0);
    chk("R4 window still open", {24'd0, rd_data}, 32'h10);
    idle(0);
    chk("R4 window closed", {24'd0, rd_data}, 32'h00);
    wr(8'h0F);
    chk("R4 late write ignored", {24'd0, rd_data}, 32'h00);
    wr(8'h18);
    for (int i = 0; i < 3; i++) idle(0);
    wr(8'h0A);
    chk("R4 write in last slot accepted", {24'd0, rd_data}, 32'h0A);

    any = 0;
    for (int i = 0; i < 48; i++) begin
      step(0, 0, 1, (i % 6 == 5), 0, 0, 8'h00);
      any |= wdt_reset;
    end
    chk("R7 kicks prevent reset", {31'd0, any}, 0);
    wr(8'h18);
    wr(8'h00);
    any = 0;
    for (int i = 0; i < 40; i++) begin idle(1); any |= wdt_reset; end
    chk("R7 disabled never resets", {31'd0, any}, 0);

    wr(8'h18);
    wr(8'h28);
    chk("R2 code bit 3 at bit 5", {24'd0, rd_data}, 32'h28);
    wr(8'h18);
    wr(8'h2C);
    chk("R2 code 12 readback", {24'd0, rd_data}, 32'h2C);
    n = 0;
    for (int i = 0; i < 1100; i++) begin
      idle(1);
      n++;
      if (wdt_reset) break;
    end
    chk("R6 code 12 clamps to 1024 ticks", n, 1024);
    step(0, 1, 0, 0, 0, 0, 8'h00);
    wr(8'h00);
    chk("R9 flag cleared", {24'd0, rd_data}, 32'h08);

    wr(8'h18);
    wr(8'h09);
    for (int i = 0; i < 3; i++) idle(1);
    wr(8'h18);
    wr(8'h09);
    any = 0;
    for (int i = 0; i < 3; i++) begin idle(1); any |= wdt_reset; end
    chk("R11 reconfig cleared count", {31'd0, any}, 0);
    idle(1);
    chk("R11 fire 4 ticks after reconfig", {31'd0, wdt_reset}, 1);
    wr(8'h00);

    force_on = 1'b1;
    wr(8'h18);
    wr(8'h00);
    chk("R10 force_on blocks disable", {24'd0, rd_data}, 32'h08);
    step(1, 0, 0, 0, 1, 0, 8'h00);
    chk("R1 por with force_on", {24'd0, rd_data}, 32'h08);

    for (int i = 0; i < 4000; i++) begin
      logic p, s, t, k, f, w;
      logic [7:0] d;
      p = ($urandom % 1000) == 0;
      s = ($urandom % 300) == 0;
      t = $urandom % 2;
      k = ($urandom % 20) == 0;
      f = force_on ^ (($urandom % 200) == 0);
      w = ($urandom % 6) == 0;
      case ($urandom % 4)
        0: d = 8'h18;
        1: d = 8'($urandom) & 8'h6F;
        2: d = 8'h00;
        default: d = 8'h08 | 8'($urandom % 3);
      endcase
      step(p, s, t, k, f, w, d);
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule